// File: doc/BRIEF.md
# Camera Link Packet Header and Checksum Checker

This block sits behind the lane merger of a camera serial receiver and sees one merged byte per cycle. It treats the first four bytes of each packet as the header: an identifier byte carrying the virtual channel and data type, a 16-bit count sent low byte first, and a parity byte. The parity byte protects the other 24 header bits with a 6-bit single-correct, double-detect Hamming code. The block repairs a header with one flipped bit. It drops any packet whose header has a fault it cannot repair. It decides from the data type whether a payload follows.

For a packet that has a payload, the block forwards that many payload bytes with a valid flag and a last-byte flag. It then reads the two trailing checksum bytes and compares them with a 16-bit CRC computed over the payload. Errors come out as single-cycle pulses, one bit per virtual channel, except for the uncorrectable-header pulse, which is global. A checksum or data-type fault does not stop delivery. Pixel unpacking and frame tracking belong to later stages.

Top module: `cam_pkt_check`

## Requirements
- R1: After reset, hdr_valid, pay_valid, pay_last and every error pulse output are 0.
- R2: hdr_valid pulses for one cycle in the cycle after the fourth header byte is accepted, with hdr_vc = byte0[7:6], hdr_dt = byte0[5:0] and hdr_wc = {byte2, byte1}.
- R3: The protected word is d = {byte2, byte1, byte0}. Parity bit j (byte3[j], j = 0..5) is the XOR of every d[i] whose code column has bit j set. The column of d[i] is the i-th value, counting from 0 in ascending order, among 6-bit values whose bit count is odd and at least 3. byte3[7:6] is ignored.
- R4: A header whose syndrome points at a single data or parity bit is corrected. It is delivered with corrected fields, and err_ecc_fix[corrected vc] pulses together with hdr_valid.
- R5: Any other nonzero syndrome, such as two flipped bits, pulses err_ecc_dbl in that cycle without hdr_valid. No payload or error pulse follows, and input bytes are discarded until a cycle with in_valid low.
- R6: Data types 0x38 to 0x3F pulse err_dt[vc] together with hdr_valid, and the packet is still delivered as a long packet.
- R7: Data types 0x00 to 0x0F are short packets with hdr_long = 0 and no payload; the next accepted byte starts a new header.
- R8: For a long packet (hdr_long = 1), each of the hdr_wc payload bytes appears on pay_data with pay_valid one cycle after acceptance, and pay_last marks the final one. A count of 0 gives no payload bytes.
- R9: The checksum is CRC-16 with polynomial x^16+x^12+x^5+1 and seed 0xFFFF, computed over the payload LSB first with no final inversion, and received low byte first. A mismatch pulses err_crc[vc] one cycle after the second checksum byte; a match gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Merged byte is valid |
| in_data | input | 8 | Merged byte |
| hdr_valid | output | 1 | Decoded header pulse |
| hdr_long | output | 1 | Decoded packet carries a payload |
| hdr_vc | output | 2 | Decoded virtual channel |
| hdr_dt | output | 6 | Decoded data type |
| hdr_wc | output | 16 | Decoded word count or short data |
| pay_valid | output | 1 | Payload byte valid |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte of the packet |
| err_ecc_fix | output | 4 | Corrected header pulse, per virtual channel |
| err_ecc_dbl | output | 1 | Uncorrectable header pulse |
| err_dt | output | 4 | Reserved data type pulse, per virtual channel |
| err_crc | output | 4 | Payload checksum mismatch pulse, per virtual channel |

## Verification
The properties assume that the bytes of one packet arrive on consecutive cycles. They also assume that at least one idle cycle follows any packet whose header may be uncorrectable, since that idle cycle is the only point where the block can resynchronise. The stimulus builds every packet as an unbroken burst and puts at least one idle cycle after any packet whose header carries two or more flips. It corrupts header bits only through explicit flip masks, so that each packet holds a known number of faults. The one exception is a back-to-back case that follows a clean short packet.

// File: rtl/cam_pkt_pkg.sv
package cam_pkt_pkg;
    localparam int VC_W     = 2;
    localparam int DT_W     = 6;
    localparam int WC_W     = 16;
    localparam int NUM_VC   = 1 << VC_W;
    localparam int HDR_BITS = VC_W + DT_W + WC_W;
    localparam int PAR_W    = 6;
    localparam int CRC_W    = 16;

    typedef enum logic [2:0] {
        ST_HDR  = 3'd0,
        ST_PAY  = 3'd1,
        ST_SUM0 = 3'd2,
        ST_SUM1 = 3'd3,
        ST_DROP = 3'd4
    } pstate_e;

    // idx-th 6-bit code with an odd bit count of at least three
    function automatic logic [PAR_W-1:0] ecc_col(input int idx);
        int n;
        logic [PAR_W-1:0] r;
        logic [PAR_W-1:0] cv;
        n = 0;
        r = '0;
        for (int v = 1; v < (1 << PAR_W); v++) begin
            cv = PAR_W'(v);
            if (($countones(cv) >= 3) && ($countones(cv) % 2 == 1)) begin
                if (n == idx) r = cv;
                n++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/cam_hdr_ecc.sv
module cam_hdr_ecc
    import cam_pkt_pkg::*;
(
    input  logic [HDR_BITS-1:0] data_in,
    input  logic [7:0]          code_in,
    output logic [HDR_BITS-1:0] data_fix,
    output logic                one_err,
    output logic                bad_hdr
);
    logic [PAR_W-1:0] col [HDR_BITS];

    for (genvar i = 0; i < HDR_BITS; i++) begin : g_col
        localparam logic [PAR_W-1:0] COL_V = ecc_col(i);
        assign col[i] = COL_V;
    end

    logic [PAR_W-1:0]    par;
    logic [PAR_W-1:0]    syn;
    logic [HDR_BITS-1:0] hit;

    always_comb begin
        par = '0;
        for (int i = 0; i < HDR_BITS; i++) begin
            for (int j = 0; j < PAR_W; j++) begin
                if (col[i][j]) par[j] = par[j] ^ data_in[i];
            end
        end
        syn = par ^ code_in[PAR_W-1:0];
        for (int i = 0; i < HDR_BITS; i++) hit[i] = (syn == col[i]);
        data_fix = data_in ^ hit;
        one_err  = (syn != '0) && ((|hit) || ($countones(syn) == 1));
        bad_hdr  = (syn != '0) && !one_err;
    end
endmodule

// File: rtl/cam_crc16.sv
module cam_crc16
    import cam_pkt_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       byte_in,
    output logic [CRC_W-1:0] crc_out
);
    localparam logic [CRC_W-1:0] POLY_REV = 16'h8408;

    always_comb begin
        crc_out = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (crc_out[0] ^ byte_in[b]) crc_out = (crc_out >> 1) ^ POLY_REV;
            else                         crc_out = crc_out >> 1;
        end
    end
endmodule

// File: rtl/cam_pkt_check.sv
module cam_pkt_check
    import cam_pkt_pkg::*;
#(
    parameter logic [DT_W-1:0] SHORT_DT_MAX = 6'h0F,
    parameter logic [DT_W-1:0] RSV_DT_MIN   = 6'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              hdr_valid,
    output logic              hdr_long,
    output logic [VC_W-1:0]   hdr_vc,
    output logic [DT_W-1:0]   hdr_dt,
    output logic [WC_W-1:0]   hdr_wc,
    output logic              pay_valid,
    output logic [7:0]        pay_data,
    output logic              pay_last,
    output logic [NUM_VC-1:0] err_ecc_fix,
    output logic              err_ecc_dbl,
    output logic [NUM_VC-1:0] err_dt,
    output logic [NUM_VC-1:0] err_crc
);
    typedef struct packed {
        pstate_e           st;
        logic [1:0]        idx;
        logic [HDR_BITS-1:0] hdr;
        logic [WC_W-1:0]   left;
        logic [VC_W-1:0]   vc;
        logic [CRC_W-1:0]  crc;
        logic [7:0]        sum_lo;
        logic              o_hv;
        logic              o_long;
        logic [VC_W-1:0]   o_vc;
        logic [DT_W-1:0]   o_dt;
        logic [WC_W-1:0]   o_wc;
        logic              o_pv;
        logic [7:0]        o_pd;
        logic              o_pl;
        logic [NUM_VC-1:0] o_fix;
        logic              o_dbl;
        logic [NUM_VC-1:0] o_dte;
        logic [NUM_VC-1:0] o_crce;
    } state_t;

    state_t q, d;

    logic [HDR_BITS-1:0] fix_hdr;
    logic                one_err, bad_hdr;
    logic [CRC_W-1:0]    crc_nx;

    cam_hdr_ecc u_ecc (
        .data_in  (q.hdr),
        .code_in  (in_data),
        .data_fix (fix_hdr),
        .one_err  (one_err),
        .bad_hdr  (bad_hdr)
    );

    cam_crc16 u_crc (
        .crc_in  (q.crc),
        .byte_in (in_data),
        .crc_out (crc_nx)
    );

    logic [DT_W-1:0] f_dt;
    logic [VC_W-1:0] f_vc;
    logic [WC_W-1:0] f_wc;
    assign f_dt = fix_hdr[DT_W-1:0];
    assign f_vc = fix_hdr[DT_W+VC_W-1:DT_W];
    assign f_wc = fix_hdr[HDR_BITS-1:DT_W+VC_W];

    always_comb begin
        d        = q;
        d.o_hv   = 1'b0;
        d.o_pv   = 1'b0;
        d.o_pl   = 1'b0;
        d.o_fix  = '0;
        d.o_dbl  = 1'b0;
        d.o_dte  = '0;
        d.o_crce = '0;
        case (q.st)
            ST_HDR: if (in_valid) begin
                case (q.idx)
                    2'd0: d.hdr[7:0]   = in_data;
                    2'd1: d.hdr[15:8]  = in_data;
                    2'd2: d.hdr[23:16] = in_data;
                    default: ;
                endcase
                d.idx = q.idx + 2'd1;
                if (q.idx == 2'd3) begin
                    if (bad_hdr) begin
                        d.o_dbl = 1'b1;
                        d.st    = ST_DROP;
                    end else begin
                        d.o_hv   = 1'b1;
                        d.o_long = (f_dt > SHORT_DT_MAX);
                        d.o_vc   = f_vc;
                        d.o_dt   = f_dt;
                        d.o_wc   = f_wc;
                        d.vc     = f_vc;
                        d.left   = f_wc;
                        d.crc    = '1;
                        if (one_err)            d.o_fix[f_vc] = 1'b1;
                        if (f_dt >= RSV_DT_MIN) d.o_dte[f_vc] = 1'b1;
                        if (f_dt > SHORT_DT_MAX)
                            d.st = (f_wc == '0) ? ST_SUM0 : ST_PAY;
                    end
                end
            end
            ST_PAY: if (in_valid) begin
                d.o_pv = 1'b1;
                d.o_pd = in_data;
                d.crc  = crc_nx;
                d.left = q.left - 1'b1;
                if (q.left == WC_W'(1)) begin
                    d.o_pl = 1'b1;
                    d.st   = ST_SUM0;
                end
            end
            ST_SUM0: if (in_valid) begin
                d.sum_lo = in_data;
                d.st     = ST_SUM1;
            end
            ST_SUM1: if (in_valid) begin
                if ({in_data, q.sum_lo} != q.crc) d.o_crce[q.vc] = 1'b1;
                d.st = ST_HDR;
            end
            ST_DROP: if (!in_valid) d.st = ST_HDR;
            default: d.st = ST_HDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hdr_valid   = q.o_hv;
    assign hdr_long    = q.o_long;
    assign hdr_vc      = q.o_vc;
    assign hdr_dt      = q.o_dt;
    assign hdr_wc      = q.o_wc;
    assign pay_valid   = q.o_pv;
    assign pay_data    = q.o_pd;
    assign pay_last    = q.o_pl;
    assign err_ecc_fix = q.o_fix;
    assign err_ecc_dbl = q.o_dbl;
    assign err_dt      = q.o_dte;
    assign err_crc     = q.o_crce;
endmodule

// File: rtl/cam_pkt_check_sva.sv
module cam_pkt_check_sva
    import cam_pkt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_valid,
    input logic              hdr_long,
    input logic [VC_W-1:0]   hdr_vc,
    input logic              pay_valid,
    input logic              pay_last,
    input logic [NUM_VC-1:0] err_ecc_fix,
    input logic              err_ecc_dbl,
    input logic [NUM_VC-1:0] err_dt,
    input logic [NUM_VC-1:0] err_crc
);
    AST_DBL_NO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        err_ecc_dbl |-> !hdr_valid); // R5
    AST_DBL_NO_PAY: assert property (@(posedge clk) disable iff (!rst_n)
        err_ecc_dbl |=> !pay_valid && err_crc == '0); // R5
    AST_FIX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_ecc_fix)); // R4
    AST_FIX_ON_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_ecc_fix) |-> hdr_valid && err_ecc_fix[hdr_vc]); // R4
    AST_DT_ON_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_dt) |-> hdr_valid && hdr_long && err_dt[hdr_vc]); // R6
    AST_CRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_crc) && !(|err_crc && pay_valid)); // R9
    AST_LAST_IN_PAY: assert property (@(posedge clk) disable iff (!rst_n)
        pay_last |-> pay_valid); // R8
    AST_SHORT_NO_PAY: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && !hdr_long |=> !pay_valid); // R7
endmodule

bind cam_pkt_check cam_pkt_check_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid   (hdr_valid),
    .hdr_long    (hdr_long),
    .hdr_vc      (hdr_vc),
    .pay_valid   (pay_valid),
    .pay_last    (pay_last),
    .err_ecc_fix (err_ecc_fix),
    .err_ecc_dbl (err_ecc_dbl),
    .err_dt      (err_dt),
    .err_crc     (err_crc)
);

// File: tb/sim_cam_pkt_check.sv
`timescale 1ns/1ps
module sim_cam_pkt_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        hdr_valid, hdr_long, pay_valid, pay_last, err_ecc_dbl;
    logic [1:0]  hdr_vc;
    logic [5:0]  hdr_dt;
    logic [15:0] hdr_wc;
    logic [7:0]  pay_data;
    logic [3:0]  err_ecc_fix, err_dt, err_crc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    cam_pkt_check u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .hdr_valid(hdr_valid), .hdr_long(hdr_long), .hdr_vc(hdr_vc),
        .hdr_dt(hdr_dt), .hdr_wc(hdr_wc), .pay_valid(pay_valid),
        .pay_data(pay_data), .pay_last(pay_last), .err_ecc_fix(err_ecc_fix),
        .err_ecc_dbl(err_ecc_dbl), .err_dt(err_dt), .err_crc(err_crc)
    );

    function automatic logic [63:0] mk(input logic hv, input logic hl,
        input logic [1:0] vc, input logic [5:0] dt, input logic [15:0] wc,
        input logic pv, input logic [7:0] pd, input logic pl,
        input logic [3:0] fx, input logic db, input logic [3:0] de,
        input logic [3:0] ce);
        return {15'd0, hv, hl, vc, dt, wc, pv, pd, pl, fx, db, de, ce};
    endfunction

    // code column of header bit idx, per R3
    function automatic logic [5:0] code_col(input int idx);
        int seen = 0;
        logic [5:0] res = 6'd0;
        for (int v = 1; v < 64; v++) begin
            int w = 0;
            for (int b = 0; b < 6; b++) w += (v >> b) & 1;
            if (w >= 3 && (w & 1) == 1) begin
                if (seen == idx) res = 6'(v);
                seen++;
            end
        end
        return res;
    endfunction

    function automatic logic [5:0] hdr_par(input logic [23:0] dw);
        logic [5:0] p = 6'd0;
        for (int i = 0; i < 24; i++) if (dw[i]) p ^= code_col(i);
        return p;
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb = r[0] ^ b[k];
            r = r >> 1;
            if (fb) r ^= 16'h8408;
        end
        return r;
    endfunction

    task automatic put(input logic [63:0] it, input string tg);
        exp_q.push_back(it);
        tag_q.push_back(tg);
    endtask

    task automatic drive(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_pkt(input logic [1:0] vc, input logic [5:0] dt,
        input logic [15:0] wc, input logic [31:0] flip, input bit bad_sum,
        input logic [7:0] seed, input int gap);
        logic [23:0] dw = {wc, vc, dt};
        logic [31:0] raw = {2'b00, hdr_par(dw), dw} ^ flip;
        int nfl = $countones(flip[29:0]);
        bit lng = (dt > 6'h0F);
        logic [3:0] dte = (dt >= 6'h38) ? 4'(1 << vc) : 4'd0;
        logic [15:0] c = 16'hFFFF;
        string tg;
        if (nfl >= 2) put(mk(0,0,0,0,0,0,0,0,0,1,0,0), "R5");
        else begin
            if (flip[31:30] != 2'b00) tg = "R3";
            else if (nfl == 1)        tg = "R4";
            else if (dte != 0)        tg = "R6";
            else if (!lng)            tg = "R7";
            else                      tg = "R2";
            put(mk(1, lng, vc, dt, wc, 0, 0, 0, (nfl == 1) ? 4'(1 << vc) : 4'd0,
                   0, dte, 0), tg);
        end
        for (int i = 0; i < 4; i++) drive(raw[8*i +: 8]);
        if (lng) begin
            for (int k = 0; k < int'(wc); k++) begin
                logic [7:0] b = seed + 8'(k * 7);
                c = crc_step(c, b);
                if (nfl < 2) put(mk(0,0,0,0,0,1,b,(k == int'(wc) - 1),0,0,0,0), "R8");
                drive(b);
            end
            if (bad_sum) c ^= 16'h0100;
            if (nfl < 2 && bad_sum) put(mk(0,0,0,0,0,0,0,0,0,0,0,4'(1 << vc)), "R9");
            drive(c[7:0]);
            drive(c[15:8]);
        end
        idle(gap);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [63:0] obs;
            obs = mk(hdr_valid, hdr_valid & hdr_long, hdr_valid ? hdr_vc : 2'd0,
                     hdr_valid ? hdr_dt : 6'd0, hdr_valid ? hdr_wc : 16'd0,
                     pay_valid, pay_valid ? pay_data : 8'd0, pay_last,
                     err_ecc_fix, err_ecc_dbl, err_dt, err_crc);
            if (obs != 64'd0) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R5/R7 unexpected output actual=%h expected=none", obs);
                end else begin
                    logic [63:0] ex;
                    string tg;
                    ex = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if (ex != obs) begin
                        errors++;
                        $display("FAIL %s actual=%h expected=%h", tg, obs, ex);
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({hdr_valid, pay_valid, pay_last, err_ecc_fix, err_ecc_dbl, err_dt, err_crc} != 0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%b expected=0",
                {hdr_valid, pay_valid, pay_last, err_ecc_fix, err_ecc_dbl, err_dt, err_crc});
        end
        rst_n = 1'b1;
        idle(2);
        send_pkt(2'd0, 6'h01, 16'h1234, 32'h0, 0, 8'h00, 1);       // R7 short
        send_pkt(2'd1, 6'h2A, 16'd5, 32'h0, 0, 8'h10, 1);          // R2 R8 R9
        send_pkt(2'd2, 6'h1E, 16'd3, 32'h0000_0080, 0, 8'h20, 1);  // R4 vc bit
        send_pkt(2'd3, 6'h08, 16'hBEEF, 32'h0400_0000, 0, 8'h0, 1);// R4 parity bit
        send_pkt(2'd1, 6'h2B, 16'd4, 32'h0010_0008, 0, 8'h30, 1);  // R5 two data bits
        send_pkt(2'd0, 6'h2B, 16'd2, 32'h0, 0, 8'h40, 1);          // recovery after drop
        send_pkt(2'd0, 6'h12, 16'd0, 32'h0, 0, 8'h00, 1);          // R8 empty payload
        send_pkt(2'd3, 6'h3A, 16'd2, 32'h0, 0, 8'h50, 1);          // R6 reserved type
        send_pkt(2'd2, 6'h24, 16'd6, 32'h0, 1, 8'h60, 1);          // R9 bad checksum
        send_pkt(2'd0, 6'h2C, 16'd3, 32'hC000_0000, 0, 8'h70, 1);  // R3 ignored bits
        send_pkt(2'd1, 6'h2D, 16'd4, 32'h0000_0200, 1, 8'h80, 1);  // R4 wc bit, R9
        send_pkt(2'd2, 6'h05, 16'h0001, 32'h2100_0000, 0, 8'h0, 1);// R5 two parity bits
        send_pkt(2'd3, 6'h02, 16'h00AA, 32'h0, 0, 8'h0, 0);        // R7 back to back
        send_pkt(2'd3, 6'h22, 16'd2, 32'h0, 0, 8'h90, 1);
        for (int n = 0; n < 20; n++) begin
            send_pkt(2'(n), 6'(16 + (n * 5) % 40), 16'(n * 3 % 41),
                     (n % 4 == 1) ? 32'(1) << (n % 30) : 32'h0, (n % 3 == 0),
                     8'(n * 11), 1);
        end
        idle(10);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending items actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule